// File: doc/BRIEF.md
# Handshaked Frame-to-Package Assembler

This block collects a wide data package from a processor-side parallel I/O port, one narrow frame at a time, and hands the finished package to a hardware accelerator. Each frame is moved under a four-phase request/acknowledge handshake. The block stores the frame into the next slice of a package register and advances a frame counter. When the final frame's handshake closes, it issues a single-cycle start to the accelerator.

After the start the block is busy. It holds the package unchanged and answers no further requests until the accelerator's done input or a synchronous clear returns it to collecting. Because all sequencing sits inside this block, the accelerator sees only a plain parallel package and a start strobe. Frame width and frames per package are parameters. The defaults are 8-bit frames and 16 frames, which gives a 128-bit package.

Top module: `frame_pkg_asm`

## Requirements
- R1: After the asynchronous reset, ack_o, start_o and busy_o are low and pkg_o is all zeros.
- R2: A frame is taken only on a rising edge of req_i while not busy. ack_o goes high on the clock edge that samples the rise. A req_i that is held high, or that is already high when the block returns to collecting, never causes a second capture.
- R3: ack_o stays high while req_i stays high. It goes low on the first clock edge that samples req_i low.
- R4: Frames are packed little-endian. The k-th frame of a package (k counted from 0) lands in pkg_o[k*FRAME_W +: FRAME_W].
- R5: start_o and busy_o both rise on the edge where the last frame's ack_o falls. start_o is high for exactly one cycle.
- R6: While busy_o is high, req_i is ignored: ack_o stays low and pkg_o stays unchanged.
- R7: A high done_i while busy clears busy_o on the next edge and leaves pkg_o as it was. The next frame taken then lands in slice 0.
- R8: clr_i, in any state, returns the block to collecting on the next edge. That edge drops ack_o and busy_o, zeroes pkg_o and resets the frame position to slice 0.
- R9: start_o stays low until all FRAME_COUNT frames of the package have completed their handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Frame request from the I/O port |
| frame_i | input | FRAME_W | Frame data, valid while req_i is high |
| ack_o | output | 1 | Frame acknowledge to the I/O port |
| clr_i | input | 1 | Synchronous clear back to collecting |
| done_i | input | 1 | Accelerator finished; releases the held package |
| pkg_o | output | FRAME_W*FRAME_COUNT | Assembled package |
| start_o | output | 1 | One-cycle start pulse to the accelerator |
| busy_o | output | 1 | Package complete and held for the accelerator |

## Verification
The assertions assume the port obeys the four-phase protocol: req_i does not drop before ack_o is seen high, and frame_i is stable while req_i is high. They also assume done_i is only pulsed after a start. The bench raises and lowers req_i only at falling clock edges, after it has observed the matching ack_o level. It holds frame_i with req_i and pulses done_i only while busy. The one deliberate break from a clean handshake is the clear issued while req_i is still high, which R8 and R2 define.

// File: rtl/asm_pkg.sv
package asm_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_ACKED   = 2'd1,
    ST_HOLD    = 2'd2
  } asm_state_e;
endpackage

// File: rtl/asm_hs.sv
module asm_hs
  import asm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  input  logic done_i,
  input  logic last_i,
  output logic take_o,
  output logic adv_o,
  output logic ack_o,
  output logic start_o,
  output logic busy_o
);
  asm_state_e state_q, state_d;
  logic req_q;
  logic ack_d, start_d;

  assign take_o = (state_q == ST_COLLECT) & req_i & ~req_q & ~clr_i;
  assign adv_o  = (state_q == ST_ACKED) & ~req_i & ~clr_i;

  always_comb begin
    state_d = state_q;
    ack_d   = ack_o;
    start_d = 1'b0;
    if (clr_i) begin
      state_d = ST_COLLECT;
      ack_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_COLLECT: if (take_o) begin
          state_d = ST_ACKED;
          ack_d   = 1'b1;
        end
        ST_ACKED: if (adv_o) begin
          ack_d = 1'b0;
          if (last_i) begin
            state_d = ST_HOLD;
            start_d = 1'b1;
          end else begin
            state_d = ST_COLLECT;
          end
        end
        ST_HOLD: if (done_i) state_d = ST_COLLECT;
        default: state_d = ST_COLLECT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_COLLECT;
      req_q   <= 1'b0;
      ack_o   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_i;
      ack_o   <= ack_d;
      start_o <= start_d;
    end
  end

  assign busy_o = (state_q == ST_HOLD);
endmodule

// File: rtl/asm_cnt.sv
module asm_cnt #(
  parameter int unsigned FRAME_COUNT = 16,
  localparam int unsigned IDX_W = $clog2(FRAME_COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_COUNT - 1);

  assign last_o = (idx_o == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (clr_i)  idx_o <= '0;
    else if (adv_i)  idx_o <= last_o ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/asm_store.sv
module asm_store #(
  parameter int unsigned FRAME_W     = 8,
  parameter int unsigned FRAME_COUNT = 16,
  localparam int unsigned IDX_W = $clog2(FRAME_COUNT),
  localparam int unsigned PKG_W = FRAME_W * FRAME_COUNT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               take_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [PKG_W-1:0]   pkg_o
);
  for (genvar g = 0; g < FRAME_COUNT; g++) begin : g_slice
    logic sel;
    assign sel = take_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pkg_o[g*FRAME_W +: FRAME_W] <= '0;
      else if (clr_i)  pkg_o[g*FRAME_W +: FRAME_W] <= '0;
      else if (sel)    pkg_o[g*FRAME_W +: FRAME_W] <= frame_i;
    end
  end
endmodule

// File: rtl/frame_pkg_asm.sv
module frame_pkg_asm #(
  parameter int unsigned FRAME_W     = 8,
  parameter int unsigned FRAME_COUNT = 16,
  localparam int unsigned IDX_W = $clog2(FRAME_COUNT),
  localparam int unsigned PKG_W = FRAME_W * FRAME_COUNT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ack_o,
  input  logic               clr_i,
  input  logic               done_i,
  output logic [PKG_W-1:0]   pkg_o,
  output logic               start_o,
  output logic               busy_o
);
  logic             take, adv, last;
  logic [IDX_W-1:0] idx;

  asm_hs i_hs (
    .clk_i, .rst_ni, .req_i, .clr_i, .done_i,
    .last_i (last),
    .take_o (take),
    .adv_o  (adv),
    .ack_o, .start_o, .busy_o
  );

  asm_cnt #(.FRAME_COUNT(FRAME_COUNT)) i_cnt (
    .clk_i, .rst_ni, .clr_i,
    .adv_i  (adv),
    .idx_o  (idx),
    .last_o (last)
  );

  asm_store #(.FRAME_W(FRAME_W), .FRAME_COUNT(FRAME_COUNT)) i_store (
    .clk_i, .rst_ni, .clr_i,
    .take_i  (take),
    .idx_i   (idx),
    .frame_i,
    .pkg_o
  );
endmodule

// File: rtl/frame_pkg_asm_chk.sv
module frame_pkg_asm_chk #(
  parameter int unsigned PKG_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             clr_i,
  input logic             done_i,
  input logic             ack_o,
  input logic             start_o,
  input logic             busy_o,
  input logic [PKG_W-1:0] pkg_o
);
  a_r2_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_i));

  a_r3_ack_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> (!$past(req_i) || $past(clr_i)));

  a_r5_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r5_start_with_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (busy_o && !ack_o));

  a_r6_busy_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ack_o);

  a_r6_busy_pkg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !clr_i) |=> $stable(pkg_o));

  a_r7_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i) |=> !busy_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ack_o && !busy_o && !start_o && (pkg_o == '0)));
endmodule

bind frame_pkg_asm frame_pkg_asm_chk #(.PKG_W(PKG_W)) i_chk (
  .clk_i, .rst_ni, .req_i, .clr_i, .done_i,
  .ack_o, .start_o, .busy_o, .pkg_o
);

// File: tb/test_frame_pkg_asm.sv
`timescale 1ns/1ps
module test_frame_pkg_asm;
  localparam int FW = 8;
  localparam int NF = 16;
  localparam int PW = FW * NF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, clr = 1'b0, done = 1'b0;
  logic [FW-1:0] frame = '0;
  logic ack, start, busy;
  logic [PW-1:0] pkg, exp_pkg;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  frame_pkg_asm #(.FRAME_W(FW), .FRAME_COUNT(NF)) i_frame_pkg_asm (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .frame_i(frame), .ack_o(ack),
    .clr_i(clr), .done_i(done), .pkg_o(pkg), .start_o(start), .busy_o(busy)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one full handshake for frame position idx
  task automatic send_frame(input logic [FW-1:0] d, input int idx, input int hold);
    @(negedge clk); req = 1'b1; frame = d;
    @(negedge clk);
    exp_pkg[idx*FW +: FW] = d;
    check(ack === 1'b1, "R2 ack after req rise", PW'(ack), PW'(1));
    check(pkg === exp_pkg, "R4 slice placement", pkg, exp_pkg);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(ack === 1'b1, "R3 ack held while req high", PW'(ack), PW'(1));
      check(pkg === exp_pkg, "R2 no recapture on held req", pkg, exp_pkg);
    end
    req = 1'b0;
    @(negedge clk);
    check(ack === 1'b0, "R3 ack drops after req low", PW'(ack), PW'(0));
    if (idx < NF - 1) begin
      check(start === 1'b0, "R9 no early start", PW'(start), PW'(0));
    end else begin
      check(start === 1'b1 && busy === 1'b1, "R5 start and busy",
            PW'({start, busy}), PW'(2'b11));
      @(negedge clk);
      check(start === 1'b0 && busy === 1'b1, "R5 start one cycle",
            PW'({start, busy}), PW'(2'b01));
    end
  endtask

  task automatic t_reset();
    check(ack === 1'b0 && start === 1'b0 && busy === 1'b0, "R1 reset outputs",
          PW'({ack, start, busy}), PW'(0));
    check(pkg === '0, "R1 reset package", pkg, '0);
  endtask

  task automatic t_full_pkg(input int seed, input int maxhold);
    for (int i = 0; i < NF; i++) send_frame(FW'(i * 37 + seed), i, i % (maxhold + 1));
    check(pkg === exp_pkg, "R4 full package", pkg, exp_pkg);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk); req = 1'b1; frame = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ack === 1'b0, "R6 no ack while busy", PW'(ack), PW'(0));
      check(pkg === exp_pkg, "R6 package held", pkg, exp_pkg);
    end
    req = 1'b0;
    @(negedge clk);
    check(busy === 1'b1, "R6 still busy", PW'(busy), PW'(1));
  endtask

  task automatic t_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    check(busy === 1'b0 && start === 1'b0, "R7 done releases",
          PW'({busy, start}), PW'(0));
    check(pkg === exp_pkg, "R7 package kept", pkg, exp_pkg);
    send_frame(8'hAA, 0, 1);
    check(pkg === exp_pkg, "R7 next frame in slice 0", pkg, exp_pkg);
  endtask

  task automatic t_clr_mid();
    send_frame(8'h11, 1, 0);
    send_frame(8'h22, 2, 0);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_pkg = '0;
    check(pkg === '0 && ack === 1'b0 && busy === 1'b0, "R8 clear mid package",
          pkg, '0);
    t_full_pkg(91, 0);
  endtask

  task automatic t_clr_req_high();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    exp_pkg = '0;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(pkg === '0, "R8 clear package", pkg, '0);
    @(negedge clk); req = 1'b1; frame = 8'h55;
    @(negedge clk);
    check(ack === 1'b1, "R2 ack before clear", PW'(ack), PW'(1));
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check(ack === 1'b0 && pkg === '0, "R8 clear drops ack", PW'(ack), PW'(0));
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(ack === 1'b0, "R2 held req not retaken", PW'(ack), PW'(0));
    end
    req = 1'b0;
    t_full_pkg(200, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_pkg = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_pkg(3, 2);
    t_busy_ignore();
    t_done();
    t_clr_mid();
    t_clr_req_high();
    t_busy_ignore();
    t_done();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule